// File: doc/BRIEF.md
# Store-Register Execution Unit

This block carries out one store-register-to-memory instruction for a small word-addressed processor. A sequencer presents the instruction word, the optional second address word, the current instruction-address value and the index-register bank, and pulses `start`. The unit decodes the instruction, forms the effective address, reads one pointer word from memory when the long format asks for indirection, and then writes the chosen register to the effective address. It pulses `done` when it finishes. It modifies no register and no indicator.

In the short format, the address is always the instruction-address value plus a sign-extended displacement. In the long format, the address comes from the second word, or from memory through it. The index registers never contribute to an address in either format, although any of them, or the instruction-address register itself, may be the stored value. An instruction word with the wrong opcode ends with `illegal` raised and no memory traffic.

Top module: `stx_exec_unit`

## Requirements
- R1: Bits 9:8 of the instruction word select the stored value: 00 is `iar_val`, 01 is index register 1 (`idx_regs[15:0]`), 10 is index register 2 (`idx_regs[31:16]`), and 11 is index register 3 (`idx_regs[47:32]`). That value appears on `mem_wdata` during the single write.
- R2: When bit 10 is 0 (short format), the write address is `iar_val` plus bits 7:0, which are taken as a signed two's-complement value. This holds for every selector value.
- R3: The index-register values never change the write address, in either format.
- R4: When bit 10 is 1 and bit 7 is 0 (long direct), the write address is `addr_word`. No memory read is issued.
- R5: When bit 10 is 1 and bit 7 is 1 (long indirect), exactly one read is issued at `addr_word`. The returned word becomes the write address.
- R6: The short-format address sum wraps modulo 2^16.
- R7: If bits 15:11 are not 01101, the operation ends with `done` and `illegal` both high, and no memory request is made. `illegal` stays low for legal instructions.
- R8: A `start` that arrives while `busy` is high is ignored. It causes no extra memory access, and the running operation keeps its own operands.
- R9: `done` is high for exactly one cycle per accepted start. `busy` falls in the cycle after `done`.
- R10: Only one memory request is outstanding at a time. While it waits for `mem_ack` (write) or `mem_rvalid` (read), the request, address, write data and write enable stay stable. No request is made while the unit is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation; sampled only when idle |
| instr_word | input | 16 | First instruction word |
| addr_word | input | 16 | Second word (long-format address) |
| iar_val | input | 16 | Instruction-address register value, already advanced |
| idx_regs | input | 48 | Index registers 1..3, packed low to high |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last accepted instruction had a wrong opcode |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Write accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
The checker assumes that memory raises `mem_ack` only for a pending write and `mem_rvalid` only for a pending read, each for a single cycle. It also assumes that operands are valid in the cycle `start` is accepted. The bench's memory responder answers only a request it has seen stay pending for a programmable number of cycles, and it returns a read word computed from the address. The bench changes the operands only on falling edges, which keeps stimulus within those assumptions.

// File: rtl/stx_pkg.sv
package stx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_IND_RD = 2'd1,
      ST_WRITE  = 2'd2,
      ST_DONE   = 2'd3
   } stx_state_e;
endpackage

// File: rtl/stx_decode.sv
module stx_decode #(
   parameter int          DATA_W = 16,
   parameter int          OPC_W  = 5,
   parameter int          DISP_W = 8,
   parameter int          T_W    = 2,
   parameter logic [4:0]  OPCODE = 5'b01101
) (
   input  logic [DATA_W-1:0] instr,
   output logic              legal,
   output logic              long_fmt,
   output logic              indirect,
   output logic [T_W-1:0]    src_sel,
   output logic [DISP_W-1:0] disp
);
   localparam int LONG_BIT = DATA_W - OPC_W - 1;

   logic [OPC_W-1:0] opc;

   assign opc      = instr[DATA_W-1 -: OPC_W];
   assign legal    = (opc == OPCODE[OPC_W-1:0]);
   assign long_fmt = instr[LONG_BIT];
   assign src_sel  = instr[DISP_W +: T_W];
   assign disp     = instr[DISP_W-1:0];
   // the top displacement bit doubles as the indirection marker in long form
   assign indirect = long_fmt & instr[DISP_W-1];
endmodule

// File: rtl/stx_src_mux.sv
module stx_src_mux #(
   parameter int DATA_W = 16,
   parameter int IDX_N  = 3,
   parameter int T_W    = 2
) (
   input  logic [DATA_W-1:0]       iar,
   input  logic [IDX_N*DATA_W-1:0] idx_regs,
   input  logic [T_W-1:0]          sel,
   output logic [DATA_W-1:0]       data
);
   logic [DATA_W-1:0] bank [IDX_N+1];

   assign bank[0] = iar;

   for (genvar g = 0; g < IDX_N; g++) begin : g_bank
      assign bank[g+1] = idx_regs[g*DATA_W +: DATA_W];
   end

   assign data = bank[sel];
endmodule

// File: rtl/stx_addr_gen.sv
module stx_addr_gen #(
   parameter int DATA_W      = 16,
   parameter int DISP_W      = 8,
   parameter bit DISP_SIGNED = 1'b1
) (
   input  logic              long_fmt,
   input  logic [DATA_W-1:0] iar,
   input  logic [DISP_W-1:0] disp,
   input  logic [DATA_W-1:0] addr_word,
   output logic [DATA_W-1:0] ea
);
   localparam int EXT_W = DATA_W - DISP_W;

   logic [DATA_W-1:0] disp_ext;

   if (DISP_SIGNED) begin : g_sext
      assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
   end else begin : g_zext
      assign disp_ext = {{EXT_W{1'b0}}, disp};
   end

   // only the instruction address or the second word feed the address
   assign ea = long_fmt ? addr_word : (iar + disp_ext);
endmodule

// File: rtl/stx_ctrl.sv
module stx_ctrl
   import stx_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              legal,
   input  logic              need_ind,
   input  logic [DATA_W-1:0] ea_in,
   input  logic [DATA_W-1:0] src_in,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata
);
   stx_state_e        state_q;
   logic [DATA_W-1:0] ea_q;
   logic [DATA_W-1:0] data_q;
   logic              illegal_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         ea_q      <= '0;
         data_q    <= '0;
         illegal_q <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ea_q      <= ea_in;
                  data_q    <= src_in;
                  illegal_q <= !legal;
                  if (!legal)        state_q <= ST_DONE;
                  else if (need_ind) state_q <= ST_IND_RD;
                  else               state_q <= ST_WRITE;
               end
            end
            ST_IND_RD: begin
               if (mem_rvalid) begin
                  ea_q    <= mem_rdata;
                  state_q <= ST_WRITE;
               end
            end
            ST_WRITE: begin
               if (mem_ack) state_q <= ST_DONE;
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_DONE);
   assign illegal   = illegal_q;
   assign mem_req   = (state_q == ST_IND_RD) || (state_q == ST_WRITE);
   assign mem_we    = (state_q == ST_WRITE);
   assign mem_addr  = ea_q;
   assign mem_wdata = data_q;
endmodule

// File: rtl/stx_exec_unit.sv
module stx_exec_unit #(
   parameter int          DATA_W      = 16,
   parameter int          OPC_W       = 5,
   parameter int          DISP_W      = 8,
   parameter int          IDX_N       = 3,
   parameter logic [4:0]  OPCODE      = 5'b01101,
   parameter bit          DISP_SIGNED = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [DATA_W-1:0]       instr_word,
   input  logic [DATA_W-1:0]       addr_word,
   input  logic [DATA_W-1:0]       iar_val,
   input  logic [IDX_N*DATA_W-1:0] idx_regs,
   output logic                    busy,
   output logic                    done,
   output logic                    illegal,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [DATA_W-1:0]       mem_addr,
   output logic [DATA_W-1:0]       mem_wdata,
   input  logic                    mem_ack,
   input  logic                    mem_rvalid,
   input  logic [DATA_W-1:0]       mem_rdata
);
   localparam int T_W = $clog2(IDX_N + 1);

   if (OPC_W + 1 + T_W + DISP_W != DATA_W) begin : g_bad_layout
      $error("instruction fields do not fill DATA_W");
   end
   if ((1 << T_W) != IDX_N + 1) begin : g_bad_sel
      $error("selector width must cover IDX_N+1 sources exactly");
   end
   if (OPC_W > 5) begin : g_bad_opc
      $error("OPC_W exceeds OPCODE parameter width");
   end

   logic              legal;
   logic              long_fmt;
   logic              indirect;
   logic [T_W-1:0]    src_sel;
   logic [DISP_W-1:0] disp;
   logic [DATA_W-1:0] ea_pre;
   logic [DATA_W-1:0] src_data;
   logic              start_ok;

   assign start_ok = start & ~busy;

   stx_decode #(
      .DATA_W(DATA_W), .OPC_W(OPC_W), .DISP_W(DISP_W),
      .T_W(T_W), .OPCODE(OPCODE)
   ) u_dec (
      .instr    (instr_word),
      .legal    (legal),
      .long_fmt (long_fmt),
      .indirect (indirect),
      .src_sel  (src_sel),
      .disp     (disp)
   );

   stx_src_mux #(
      .DATA_W(DATA_W), .IDX_N(IDX_N), .T_W(T_W)
   ) u_src (
      .iar      (iar_val),
      .idx_regs (idx_regs),
      .sel      (src_sel),
      .data     (src_data)
   );

   stx_addr_gen #(
      .DATA_W(DATA_W), .DISP_W(DISP_W), .DISP_SIGNED(DISP_SIGNED)
   ) u_ea (
      .long_fmt  (long_fmt),
      .iar       (iar_val),
      .disp      (disp),
      .addr_word (addr_word),
      .ea        (ea_pre)
   );

   stx_ctrl #(
      .DATA_W(DATA_W)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_ok),
      .legal      (legal),
      .need_ind   (indirect),
      .ea_in      (ea_pre),
      .src_in     (src_data),
      .busy       (busy),
      .done       (done),
      .illegal    (illegal),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata)
   );
endmodule

// File: rtl/stx_exec_checker.sv
module stx_exec_checker #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              done,
   input logic              illegal,
   input logic              mem_req,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              mem_rvalid
);
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R9
   AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done));                                 // R9
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !mem_rvalid) |=>
         (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);                                          // R10
   AST_NO_REQ_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !illegal);                                        // R7
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req);                                           // R10
endmodule

bind stx_exec_unit stx_exec_checker #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy),
   .done       (done),
   .illegal    (illegal),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_ack    (mem_ack),
   .mem_rvalid (mem_rvalid)
);

// File: tb/sim_stx_exec_unit.sv
module sim_stx_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] instr_word = '0;
   logic [15:0] addr_word = '0;
   logic [15:0] iar_val = 16'h1200;
   logic [47:0] idx_regs = {16'h3333, 16'h2222, 16'h1111};
   logic        busy, done, illegal, mem_req, mem_we;
   logic [15:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ack, mem_rvalid;

   int checks = 0;
   int errors = 0;
   int lat = 1;
   int wait_cnt = 0;
   int wr_cnt = 0;
   int rd_cnt = 0;
   logic [15:0] last_wa, last_wd, last_ra;
   logic got_done, got_ill;

   always #4 clk = ~clk;

   stx_exec_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
      .addr_word(addr_word), .iar_val(iar_val), .idx_regs(idx_regs),
      .busy(busy), .done(done), .illegal(illegal), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   // memory responder: read word is the address xor a constant
   assign mem_rdata = mem_addr ^ 16'h5A5A;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0; mem_rvalid <= 1'b0; wait_cnt <= 0;
      end else begin
         mem_ack <= 1'b0; mem_rvalid <= 1'b0;
         if (mem_req && !mem_ack && !mem_rvalid) begin
            if (wait_cnt >= lat) begin
               wait_cnt <= 0;
               if (mem_we) mem_ack <= 1'b1; else mem_rvalid <= 1'b1;
            end else wait_cnt <= wait_cnt + 1;
         end
         if (mem_req && mem_we && mem_ack) begin
            wr_cnt <= wr_cnt + 1; last_wa <= mem_addr; last_wd <= mem_wdata;
         end
         if (mem_req && !mem_we && mem_rvalid) begin
            rd_cnt <= rd_cnt + 1; last_ra <= mem_addr;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input logic [15:0] iw, input logic [15:0] aw);
      got_done = 1'b0; got_ill = 1'b0;
      @(negedge clk);
      instr_word = iw; addr_word = aw; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 200 && !got_done; k++) begin
         if (done) begin got_done = 1'b1; got_ill = illegal; end
         else @(negedge clk);
      end
      @(negedge clk);
   endtask

   // instr, second word, expected address, expected data, flags (bit0 illegal, bit1 indirect)
   localparam logic [79:0] VEC [9] = '{
      {16'h6805, 16'h0000, 16'h1205, 16'h1200, 16'h0000},
      {16'h69FF, 16'h0000, 16'h11FF, 16'h1111, 16'h0000},
      {16'h6A80, 16'h0000, 16'h1180, 16'h2222, 16'h0000},
      {16'h6B7F, 16'h0000, 16'h127F, 16'h3333, 16'h0000},
      {16'h6C00, 16'h4000, 16'h4000, 16'h1200, 16'h0000},
      {16'h6D00, 16'h0ABC, 16'h0ABC, 16'h1111, 16'h0000},
      {16'h6E80, 16'h0100, 16'h5B5A, 16'h2222, 16'h0002},
      {16'h6F80, 16'hFFFF, 16'hA5A5, 16'h3333, 16'h0002},
      {16'h7000, 16'h0000, 16'h0000, 16'h0000, 16'h0001}
   };

   initial begin
      int w0, r0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !mem_req && !illegal, "R9 reset state",
          {12'h0, busy, done, mem_req, illegal}, 16'h0000);
      rst_n = 1'b1;

      for (int i = 0; i < 9; i++) begin
         logic [15:0] iw, aw, ea, dd, fl;
         {iw, aw, ea, dd, fl} = VEC[i];
         lat = i % 3;
         w0 = wr_cnt; r0 = rd_cnt;
         run(iw, aw);
         chk(got_done, "R9 done seen", {15'h0, got_done}, 16'h1);
         chk(got_ill == fl[0], "R7 illegal flag", {15'h0, got_ill}, {15'h0, fl[0]});
         if (fl[0]) begin
            chk(wr_cnt == w0 && rd_cnt == r0, "R7 no memory access",
                16'(wr_cnt - w0 + rd_cnt - r0), 16'h0);
         end else begin
            chk(wr_cnt == w0 + 1, "R1 one write", 16'(wr_cnt - w0), 16'h1);
            chk(last_wa == ea, "R2 R4 R5 write address", last_wa, ea);
            chk(last_wd == dd, "R1 write data", last_wd, dd);
            chk(rd_cnt == r0 + (fl[1] ? 1 : 0), "R4 R5 read count",
                16'(rd_cnt - r0), {15'h0, fl[1]});
            if (fl[1]) chk(last_ra == aw, "R5 pointer address", last_ra, aw);
         end
      end

      // R6: short-format wrap
      iar_val = 16'hFFF0; lat = 0; w0 = wr_cnt;
      run(16'h6820, 16'h0000);
      chk(last_wa == 16'h0010, "R6 wrap address", last_wa, 16'h0010);
      chk(last_wd == 16'hFFF0, "R6 stored iar", last_wd, 16'hFFF0);

      // R3: index registers do not move the address
      iar_val = 16'h1200; idx_regs = {16'hFFFF, 16'h8000, 16'h7FFF};
      run(16'h6A05, 16'h0000);
      chk(last_wa == 16'h1205, "R3 short address", last_wa, 16'h1205);
      chk(last_wd == 16'h8000, "R3 data xr2", last_wd, 16'h8000);
      run(16'h6F00, 16'h2468);
      chk(last_wa == 16'h2468, "R3 long address", last_wa, 16'h2468);

      // R8: start while busy is ignored
      idx_regs = {16'h3333, 16'h2222, 16'h1111}; lat = 6; w0 = wr_cnt; r0 = rd_cnt;
      @(negedge clk);
      instr_word = 16'h6905; start = 1'b1;
      @(negedge clk);
      instr_word = 16'h6F80; addr_word = 16'h0100; iar_val = 16'h0000;
      repeat (2) @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      chk(wr_cnt == w0 + 1, "R8 single write", 16'(wr_cnt - w0), 16'h1);
      chk(rd_cnt == r0, "R8 no extra read", 16'(rd_cnt - r0), 16'h0);
      chk(last_wa == 16'h1205, "R8 address kept", last_wa, 16'h1205);
      chk(last_wd == 16'h1111, "R8 data kept", last_wd, 16'h1111);
      chk(!busy, "R9 idle afterwards", {15'h0, busy}, 16'h0);

      // R7 flag clears on the next legal instruction
      iar_val = 16'h1200; lat = 0;
      run(16'h0000, 16'h0000);
      chk(got_ill, "R7 illegal zero word", {15'h0, got_ill}, 16'h1);
      run(16'h6B00, 16'h0000);
      chk(!got_ill && last_wd == 16'h3333, "R7 flag cleared", {15'h0, got_ill}, 16'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R9 actual=%h expected=%h", 16'h0, 16'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule